// File: doc/BRIEF.md
# Static Wear-Leveling Block Remapper

This block translates logical block numbers into physical flash block numbers for a small array. It spreads erase wear over every physical block, including blocks whose contents never change. The host addresses only logical blocks. Each write moves the logical block to a new physical home, and the host takes no part in this.

On a host write the block scans the erase counters of all physical blocks. It skips the block that currently holds the written logical address and picks the one with the fewest erases. If that block is unused, the block erases it and programs it. If it holds data of another logical address, that data is first copied into the block the written address is leaving. The leaving block is erased just before the copy. The counters and the forward and reverse maps are updated as the flash back-end accepts each command. Reads only translate and answer one cycle later.

Top module: `wl_remap_top`

## Requirements
- R1: After reset, logical block i maps to physical block i, every erase counter is zero, wr_ready is high and cmd_valid is low.
- R2: A read request (rd_valid with rd_lba) gives rd_resp_valid high on the next cycle, with rd_pba holding the current physical block of rd_lba. Reads issue no command and change no counter.
- R3: The write target is the physical block with the lowest erase count, excluding the block currently mapped to the written logical address. Ties go to the lowest index. A count is the number of ERASE commands issued to that block and saturates at 2^CNT_W-1 without wrapping.
- R4: If the target holds no valid data, the commands are ERASE(target) then PROGRAM(target). The previous block of the written address becomes free.
- R5: If the target holds data of another logical address (the victim), the commands are ERASE(old), COPY(src=target, dst=old), ERASE(target), PROGRAM(target). The victim then maps to the old block.
- R6: After the PROGRAM command is accepted, the written logical address maps to the target block.
- R7: cmd_op uses 1 for ERASE, 2 for COPY and 3 for PROGRAM. cmd_dst names the block erased or written, and cmd_src is meaningful only for COPY. A command stays valid, with the same op, src and dst, until cmd_ready is seen.
- R8: wr_ready is low from the accepted write until the PROGRAM command is accepted, and high again on the cycle after.
- R9: Repeated writes to a single logical address issue erases to every physical block, including blocks that first held unchanging data.
- R10: Every valid physical block is owned by a logical address that maps back to it, and no two logical addresses share a physical block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Block idle; write accepted when both high |
| wr_lba | input | LA_W | Logical block to write |
| rd_valid | input | 1 | Translation request |
| rd_lba | input | LA_W | Logical block to translate |
| rd_resp_valid | output | 1 | Translation result valid |
| rd_pba | output | PA_W | Physical block of the requested logical block |
| cmd_valid | output | 1 | Back-end command valid |
| cmd_ready | input | 1 | Back-end accepts command |
| cmd_op | output | 2 | 1 erase, 2 copy, 3 program |
| cmd_src | output | PA_W | Copy source block |
| cmd_dst | output | PA_W | Erased, copied-to or programmed block |

## Verification
Translation requests and remapping can fall in the same cycle. A read of the logical address being written may arrive while its first flash command is stalled by the back-end. The bench provokes this by holding cmd_ready low and issuing a read in that window. The answer must still be the old physical block, because the mapping only moves when PROGRAM is accepted, and the stalled command must stay unchanged. The full map is then read back after writes and compared with an arithmetic model.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_COPY  = 2'd2,
        OP_PROG  = 2'd3
    } wl_op_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SCAN      = 3'd1,
        S_DECIDE    = 3'd2,
        S_ERASE_OLD = 3'd3,
        S_COPY      = 3'd4,
        S_ERASE_TGT = 3'd5,
        S_PROG      = 3'd6
    } wl_st_e;
endpackage

// File: rtl/wl_wear_ctr.sv
module wl_wear_ctr #(
    parameter int N_PHYS = 10,
    parameter int CNT_W  = 16,
    localparam int PA_W  = $clog2(N_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [PA_W-1:0]  inc_idx,
    input  logic [PA_W-1:0]  rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    logic [CNT_W-1:0] cnt_q [N_PHYS];
    logic [CNT_W-1:0] cnt_d [N_PHYS];

    always_comb begin
        cnt_d = cnt_q;
        if (inc_en && cnt_q[inc_idx] != {CNT_W{1'b1}})
            cnt_d[inc_idx] = cnt_q[inc_idx] + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PHYS; i++) cnt_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rd_cnt = cnt_q[rd_idx];

    for (genvar g = 0; g < N_PHYS; g++) begin : g_chk
        // R3
        cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] >= $past(cnt_q[g]));
    end
endmodule

// File: rtl/wl_min_scan.sv
module wl_min_scan #(
    parameter int N_PHYS = 10,
    parameter int CNT_W  = 16,
    localparam int PA_W  = $clog2(N_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PA_W-1:0]  excl,
    output logic [PA_W-1:0]  rd_idx,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic             done,
    output logic [PA_W-1:0]  best
);
    localparam logic [PA_W-1:0] LAST = PA_W'(N_PHYS - 1);

    typedef struct packed {
        logic             busy;
        logic [PA_W-1:0]  idx;
        logic             have;
        logic [PA_W-1:0]  best;
        logic [CNT_W-1:0] bcnt;
        logic             done;
    } scan_s;

    scan_s scan_d, scan_q;

    always_comb begin
        scan_d      = scan_q;
        scan_d.done = 1'b0;
        if (start) begin
            scan_d.busy = 1'b1;
            scan_d.idx  = '0;
            scan_d.have = 1'b0;
        end else if (scan_q.busy) begin
            if (scan_q.idx != excl && (!scan_q.have || rd_cnt < scan_q.bcnt)) begin
                scan_d.have = 1'b1;
                scan_d.best = scan_q.idx;
                scan_d.bcnt = rd_cnt;
            end
            if (scan_q.idx == LAST) begin
                scan_d.busy = 1'b0;
                scan_d.done = 1'b1;
            end else begin
                scan_d.idx = scan_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign rd_idx = scan_q.idx;
    assign done   = scan_q.done;
    assign best   = scan_q.best;

    // R3
    best_not_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best != excl) && scan_q.have);
    // R3
    scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q.busy |-> scan_q.idx <= LAST);
endmodule

// File: rtl/wl_map.sv
module wl_map #(
    parameter int N_LOG  = 8,
    parameter int N_PHYS = 10,
    localparam int LA_W  = $clog2(N_LOG),
    localparam int PA_W  = $clog2(N_PHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [LA_W-1:0] set_lba,
    input  logic [PA_W-1:0] set_pba,
    input  logic            clr_en,
    input  logic [PA_W-1:0] clr_pba,
    input  logic [LA_W-1:0] rd_lba,
    output logic [PA_W-1:0] rd_pba,
    input  logic [LA_W-1:0] wr_lba,
    output logic [PA_W-1:0] wr_pba,
    input  logic [PA_W-1:0] q_pba,
    output logic            q_valid,
    output logic [LA_W-1:0] q_owner
);
    logic [PA_W-1:0] fwd_q   [N_LOG];
    logic [PA_W-1:0] fwd_d   [N_LOG];
    logic [LA_W-1:0] owner_q [N_PHYS];
    logic [LA_W-1:0] owner_d [N_PHYS];
    logic [N_PHYS-1:0] valid_q, valid_d;

    always_comb begin
        fwd_d   = fwd_q;
        owner_d = owner_q;
        valid_d = valid_q;
        if (clr_en) valid_d[clr_pba] = 1'b0;
        if (set_en) begin
            fwd_d[set_lba]   = set_pba;
            owner_d[set_pba] = set_lba;
            valid_d[set_pba] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LOG; i++) fwd_q[i] <= PA_W'(i);
            for (int i = 0; i < N_PHYS; i++) begin
                owner_q[i] <= (i < N_LOG) ? LA_W'(i) : '0;
                valid_q[i] <= (i < N_LOG);
            end
        end else begin
            fwd_q   <= fwd_d;
            owner_q <= owner_d;
            valid_q <= valid_d;
        end
    end

    assign rd_pba  = fwd_q[rd_lba];
    assign wr_pba  = fwd_q[wr_lba];
    assign q_valid = valid_q[q_pba];
    assign q_owner = owner_q[q_pba];

    for (genvar g = 0; g < N_PHYS; g++) begin : g_chk
        // R10
        owner_maps_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[g] |-> fwd_q[owner_q[g]] == PA_W'(g));
    end
endmodule

// File: rtl/wl_remap_top.sv
module wl_remap_top #(
    parameter int N_LOG  = 8,
    parameter int N_PHYS = 10,
    parameter int CNT_W  = 16,
    localparam int LA_W  = $clog2(N_LOG),
    localparam int PA_W  = $clog2(N_PHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  logic [LA_W-1:0] wr_lba,
    input  logic            rd_valid,
    input  logic [LA_W-1:0] rd_lba,
    output logic            rd_resp_valid,
    output logic [PA_W-1:0] rd_pba,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [1:0]      cmd_op,
    output logic [PA_W-1:0] cmd_src,
    output logic [PA_W-1:0] cmd_dst
);
    import wl_pkg::*;

    typedef struct packed {
        wl_st_e          st;
        logic [LA_W-1:0] lba;
        logic [PA_W-1:0] old;
        logic [PA_W-1:0] tgt;
        logic [LA_W-1:0] victim;
        logic            reloc;
        logic            rd_vld;
        logic [PA_W-1:0] rd_pba;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic            scan_start, scan_done;
    logic [PA_W-1:0] scan_best, scan_idx;
    logic [CNT_W-1:0] scan_cnt;
    logic            inc_en;
    logic [PA_W-1:0] inc_idx;
    logic            set_en, clr_en;
    logic [LA_W-1:0] set_lba;
    logic [PA_W-1:0] set_pba, clr_pba;
    logic [PA_W-1:0] map_rd_pba, map_wr_pba;
    logic            tgt_valid;
    logic [LA_W-1:0] tgt_owner;
    wl_op_e          op;

    wl_wear_ctr #(.N_PHYS(N_PHYS), .CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_idx(inc_idx),
        .rd_idx(scan_idx), .rd_cnt(scan_cnt));

    wl_min_scan #(.N_PHYS(N_PHYS), .CNT_W(CNT_W)) scan_i (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .excl(ctl_q.old),
        .rd_idx(scan_idx), .rd_cnt(scan_cnt), .done(scan_done), .best(scan_best));

    wl_map #(.N_LOG(N_LOG), .N_PHYS(N_PHYS)) map_i (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_lba(set_lba),
        .set_pba(set_pba), .clr_en(clr_en), .clr_pba(clr_pba),
        .rd_lba(rd_lba), .rd_pba(map_rd_pba), .wr_lba(wr_lba),
        .wr_pba(map_wr_pba), .q_pba(ctl_q.tgt), .q_valid(tgt_valid),
        .q_owner(tgt_owner));

    always_comb begin
        ctl_d      = ctl_q;
        scan_start = 1'b0;
        inc_en     = 1'b0;
        inc_idx    = '0;
        set_en     = 1'b0;
        set_lba    = '0;
        set_pba    = '0;
        clr_en     = 1'b0;
        clr_pba    = '0;
        cmd_valid  = 1'b0;
        op         = OP_NONE;
        cmd_src    = '0;
        cmd_dst    = '0;

        ctl_d.rd_vld = rd_valid;
        if (rd_valid) ctl_d.rd_pba = map_rd_pba;

        case (ctl_q.st)
            S_IDLE: begin
                if (wr_valid) begin
                    ctl_d.lba  = wr_lba;
                    ctl_d.old  = map_wr_pba;
                    scan_start = 1'b1;
                    ctl_d.st   = S_SCAN;
                end
            end
            S_SCAN: begin
                if (scan_done) begin
                    ctl_d.tgt = scan_best;
                    ctl_d.st  = S_DECIDE;
                end
            end
            S_DECIDE: begin
                ctl_d.reloc = tgt_valid;
                if (tgt_valid) begin
                    ctl_d.victim = tgt_owner;
                    ctl_d.st     = S_ERASE_OLD;
                end else begin
                    ctl_d.st = S_ERASE_TGT;
                end
            end
            S_ERASE_OLD: begin
                cmd_valid = 1'b1;
                op        = OP_ERASE;
                cmd_dst   = ctl_q.old;
                if (cmd_ready) begin
                    inc_en   = 1'b1;
                    inc_idx  = ctl_q.old;
                    ctl_d.st = S_COPY;
                end
            end
            S_COPY: begin
                cmd_valid = 1'b1;
                op        = OP_COPY;
                cmd_src   = ctl_q.tgt;
                cmd_dst   = ctl_q.old;
                if (cmd_ready) begin
                    set_en   = 1'b1;
                    set_lba  = ctl_q.victim;
                    set_pba  = ctl_q.old;
                    clr_en   = 1'b1;
                    clr_pba  = ctl_q.tgt;
                    ctl_d.st = S_ERASE_TGT;
                end
            end
            S_ERASE_TGT: begin
                cmd_valid = 1'b1;
                op        = OP_ERASE;
                cmd_dst   = ctl_q.tgt;
                if (cmd_ready) begin
                    inc_en   = 1'b1;
                    inc_idx  = ctl_q.tgt;
                    ctl_d.st = S_PROG;
                end
            end
            S_PROG: begin
                cmd_valid = 1'b1;
                op        = OP_PROG;
                cmd_dst   = ctl_q.tgt;
                if (cmd_ready) begin
                    set_en   = 1'b1;
                    set_lba  = ctl_q.lba;
                    set_pba  = ctl_q.tgt;
                    clr_en   = !ctl_q.reloc;
                    clr_pba  = ctl_q.old;
                    ctl_d.st = S_IDLE;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cmd_op        = op;
    assign wr_ready      = (ctl_q.st == S_IDLE);
    assign rd_resp_valid = ctl_q.rd_vld;
    assign rd_pba        = ctl_q.rd_pba;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
                                    && $stable(cmd_src) && $stable(cmd_dst));
    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !wr_ready);
    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_resp_valid);
    // R3
    tgt_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_ERASE_TGT) |-> ctl_q.tgt != ctl_q.old);
    // R5
    copy_src_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> cmd_src != cmd_dst);
    // R8
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> wr_ready);
endmodule

// File: tb/wl_remap_top_tb_top.sv
module wl_remap_top_tb_top;
    localparam int NL = 8;
    localparam int NP = 10;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0, cmd_ready = 1'b0;
    logic [2:0] wr_lba = '0, rd_lba = '0;
    logic wr_ready, rd_resp_valid, cmd_valid;
    logic [3:0] rd_pba, cmd_src, cmd_dst;
    logic [1:0] cmd_op;

    int n_chk = 0, n_fail = 0;
    int m_fwd [NL];
    int m_own [NP];
    int m_val [NP];
    int m_cnt [NP];
    int obs_erase [NP];

    always #10 clk = ~clk;

    wl_remap_top #(.N_LOG(NL), .N_PHYS(NP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_lba(wr_lba), .rd_valid(rd_valid), .rd_lba(rd_lba),
        .rd_resp_valid(rd_resp_valid), .rd_pba(rd_pba), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_one(input int l, input int exp, input string req);
        rd_valid = 1'b1;
        rd_lba   = 3'(l);
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(rd_resp_valid === 1'b1, {req, " rd_resp_valid"}, int'(rd_resp_valid), 1);
        chk(int'(rd_pba) == exp, {req, " rd_pba"}, int'(rd_pba), exp);
    endtask

    task automatic read_all(input string req);
        bit [NP-1:0] used = '0;
        for (int l = 0; l < NL; l++) begin
            read_one(l, m_fwd[l], req);
            chk(!used[rd_pba], "R10 distinct physical blocks", int'(rd_pba), -1);
            used[rd_pba] = 1'b1;
        end
    endtask

    // R7 encodings: 1 erase, 2 copy, 3 program
    task automatic expect_cmd(input int op, input int src, input int dst, input int stall,
                              input int chk_lba, input int chk_pba, input string req);
        int w = 0;
        while (cmd_valid !== 1'b1 && w < 64) begin
            @(negedge clk);
            w++;
        end
        chk(cmd_valid === 1'b1, {req, " cmd_valid"}, int'(cmd_valid), 1);
        if (chk_lba >= 0) begin
            read_one(chk_lba, chk_pba, "R2 read during remap");
            chk(cmd_valid === 1'b1 && int'(cmd_op) == op, "R7 held during read",
                int'(cmd_op), op);
        end
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(cmd_valid === 1'b1 && int'(cmd_dst) == dst, "R7 held while stalled",
                int'(cmd_dst), dst);
        end
        chk(int'(cmd_op) == op, {req, " cmd_op"}, int'(cmd_op), op);
        chk(int'(cmd_dst) == dst, {req, " cmd_dst"}, int'(cmd_dst), dst);
        if (op == 2) chk(int'(cmd_src) == src, {req, " cmd_src"}, int'(cmd_src), src);
        if (cmd_op == 2'd1) obs_erase[cmd_dst]++;
        cmd_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic do_write(input int l, input int stall);
        int old = m_fwd[l];
        int tgt = -1;
        for (int p = 0; p < NP; p++)
            if (p != old && (tgt < 0 || m_cnt[p] < m_cnt[tgt])) tgt = p;
        chk(wr_ready === 1'b1, "R8 ready when idle", int'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_lba   = 3'(l);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready === 1'b0, "R8 busy after accept", int'(wr_ready), 0);
        if (m_val[tgt] != 0) begin
            int v = m_own[tgt];
            expect_cmd(1, 0, old, stall, l, old, "R5 R3 erase old");
            if (m_cnt[old] < CMAX) m_cnt[old]++;
            expect_cmd(2, tgt, old, stall, -1, 0, "R5 copy");
            m_fwd[v] = old; m_own[old] = v; m_val[tgt] = 0;
            expect_cmd(1, 0, tgt, stall, -1, 0, "R5 R3 erase target");
            if (m_cnt[tgt] < CMAX) m_cnt[tgt]++;
            expect_cmd(3, 0, tgt, stall, -1, 0, "R5 program");
        end else begin
            expect_cmd(1, 0, tgt, stall, l, old, "R4 R3 erase free target");
            if (m_cnt[tgt] < CMAX) m_cnt[tgt]++;
            expect_cmd(3, 0, tgt, stall, -1, 0, "R4 program");
            m_val[old] = 0;
        end
        m_fwd[l] = tgt; m_own[tgt] = l; m_val[tgt] = 1;
        chk(wr_ready === 1'b1, "R8 ready after program", int'(wr_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_own[p] = (p < NL) ? p : 0;
            m_val[p] = (p < NL) ? 1 : 0;
            m_cnt[p] = 0;
            obs_erase[p] = 0;
        end
        for (int l = 0; l < NL; l++) m_fwd[l] = l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready === 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
        chk(cmd_valid === 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        read_all("R1 identity map");

        // hot address: drives counters into saturation (R3)
        for (int i = 0; i < 120; i++) begin
            do_write(3, i % 3);
            if (i % 10 == 9) read_all("R6 map after hot writes");
        end
        for (int p = 0; p < NP; p++)
            chk(obs_erase[p] > 0, "R9 every block erased", obs_erase[p], 1);
        chk(m_cnt[0] == CMAX, "R3 saturated count model", m_cnt[0], CMAX);

        // sweep across all logical addresses
        for (int i = 0; i < 80; i++) begin
            do_write(i % NL, (i + 1) % 4);
            read_all("R6 map after sweep write");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule